// File: doc/BRIEF.md
# Streaming Reed-Solomon Block Encoder

This block turns a framed stream of 8-bit message symbols into systematic Reed-Solomon codewords with 16 check symbols each. Upstream logic offers symbols with a valid/ready handshake and marks the first and last symbol of a message with start and end flags. The encoder sends every accepted symbol unchanged to a framed output, two cycles after the cycle in which it was accepted. It then appends the 16 check symbols that an LFSR bank of constant Galois-field multipliers has built up.

Each codeword is 16 symbols longer at the output than at the input. For this reason the encoder drops its input ready while the check symbols drain. A low output ready freezes the whole encoder. A message may be shorter than 239 symbols, which gives a shortened code. If the end flag never arrives, the 239th symbol closes the message.

Top module: `rs_stream_encoder`

## Requirements
- R1: A symbol is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while `out_ready` is high and no check symbols are waiting to drain.
- R2: Accepted symbols leave on `out_data` in their original order. A symbol accepted in cycle n is presented in cycle n+2 when the output never stalls. `out_sop` is high only on the first symbol of each codeword.
- R3: The 16 check symbols follow the last message symbol directly, with the highest-degree remainder coefficient first. `out_eop` is high only on the final check symbol, which appears 16 cycles after the last message symbol when the output never stalls.
- R4: Symbols are elements of GF(2^8) with field polynomial 0x11D. Take the first output symbol as the highest-degree coefficient of the codeword polynomial c(x). Then c(2^i) = 0 for every i from 0 to 15, because c(x) is a multiple of the product of (x + 2^i) over those i.
- R5: After the last message symbol is accepted, `in_ready` stays low until the final check symbol has been taken. With `out_ready` held high this lasts 17 cycles, and `in_ready` is high again in the 18th.
- R6: While `out_ready` is low, `in_ready` is low and every output holds its value.
- R7: A message closed by `in_eop` after L symbols, for any L from 1 to 239, yields exactly L+16 output symbols.
- R8: If `in_eop` is not seen, the 239th accepted symbol ends the message, and the check symbols follow with the same timing as in R3.
- R9: After `rst_n` is released and two clock edges have passed, `out_valid` is low and `in_ready` equals `out_ready`.
- R10: Each codeword's check symbols depend only on that codeword's message. The parity bank is zero once the last check symbol has been taken, including for back-to-back codewords.
- R11: `in_data`, `in_sop` and `in_eop` have no effect in cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Encoder can take a symbol this cycle |
| in_sop | input | 1 | First symbol of a message |
| in_eop | input | 1 | Last symbol of a message |
| in_data | input | 8 | Message symbol |
| out_valid | output | 1 | Output symbol present |
| out_ready | input | 1 | Downstream takes the output symbol; low freezes the encoder |
| out_sop | output | 1 | First symbol of a codeword |
| out_eop | output | 1 | Last check symbol of a codeword |
| out_data | output | 8 | Codeword symbol |

## Verification
Several kinds of message are used. Single-symbol and two-symbol messages test the shortest shortened codes. A full 239-symbol message ends with the end flag, and another ends without it, which shows whether the count limit closes the codeword. Random-length messages are sent back to back at full rate, which tests that the parity bank clears between codewords. Random-length messages are also sent with random gaps on both valid and ready, which tests stalls and garbage on idle inputs. Each codeword is judged by comparing its message part against the recorded input and by evaluating its 16 syndromes. This separates wrong multiplier constants, wrong drain order and missing parity clears from plain framing errors. Full-rate runs also measure the pass-through latency and the length of the input stall.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

  typedef logic [SYM_W-1:0] sym_t;
  typedef enum logic {ST_DATA = 1'b0, ST_DRAIN = 1'b1} enc_state_e;

  // Multiply two field elements, reducing by the field polynomial.
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t x;
    sym_t y;
    acc = '0;
    x   = a;
    y   = b;
    for (int i = 0; i < SYM_W; i++) begin
      if (y[0]) acc = acc ^ x;
      y = y >> 1;
      x = x[SYM_W-1] ? ((x << 1) ^ FIELD_POLY[SYM_W-1:0]) : (x << 1);
    end
    return acc;
  endfunction

  // Coefficient idx of the monic generator: product of (x + 2^i), i < npar.
  function automatic sym_t gen_coef(int npar, int idx);
    sym_t g [64];
    sym_t root;
    for (int j = 0; j < 64; j++) g[j] = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int i = 0; i < npar; i++) begin
      for (int j = i + 1; j >= 0; j--) begin
        if (j > 0) g[j] = g[j-1] ^ gf_mul(g[j], root);
        else       g[j] = gf_mul(g[j], root);
      end
      root = gf_mul(root, sym_t'(2));
    end
    return g[idx];
  endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
  import rs_enc_pkg::*;
#(
  parameter sym_t COEF = sym_t'(1)
) (
  input  sym_t a,
  output sym_t y
);
  // Second operand is a constant, so this reduces to an XOR network.
  always_comb y = gf_mul(a, COEF);
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rs_enc_pkg::*;
#(
  parameter int N_PAR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic absorb,
  input  logic emit,
  input  sym_t din,
  output sym_t par_top,
  output logic par_empty
);
  sym_t par_q [N_PAR];
  sym_t par_d [N_PAR];
  sym_t prod  [N_PAR];
  sym_t fb;

  assign fb = din ^ par_q[N_PAR-1];

  generate
    for (genvar i = 0; i < N_PAR; i++) begin : g_tap
      rs_gf_cmul #(.COEF(gen_coef(N_PAR, i))) u_mul (
        .a (fb),
        .y (prod[i])
      );
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < N_PAR; i++) par_d[i] = par_q[i];
    if (absorb) begin
      par_d[0] = prod[0];
      for (int i = 1; i < N_PAR; i++) par_d[i] = par_q[i-1] ^ prod[i];
    end else if (emit) begin
      par_d[0] = '0;
      for (int i = 1; i < N_PAR; i++) par_d[i] = par_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PAR; i++) par_q[i] <= '0;
    end else if (absorb || emit) begin
      for (int i = 0; i < N_PAR; i++) par_q[i] <= par_d[i];
    end
  end

  assign par_top = par_q[N_PAR-1];

  always_comb begin
    par_empty = 1'b1;
    for (int i = 0; i < N_PAR; i++) if (par_q[i] != '0) par_empty = 1'b0;
  end

  // R3: the bank never absorbs and drains in the same cycle
  a_r3_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(absorb && emit));
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int K_MAX = 239,
  parameter int N_PAR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic in_valid,
  input  logic in_eop,
  input  logic s1_valid,
  output logic in_ready,
  output logic accept,
  output logic emit_par,
  output logic par_last
);
  localparam int MC_W = $clog2(K_MAX + 1);
  localparam int PC_W = $clog2(N_PAR);

  enc_state_e      state_q, state_d;
  logic [MC_W-1:0] msg_cnt_q, msg_cnt_d;
  logic [PC_W-1:0] par_cnt_q, par_cnt_d;
  logic            last_sym;

  assign in_ready = en && rst_n && (state_q == ST_DATA);
  assign accept   = in_valid && in_ready;
  assign last_sym = accept && (in_eop || (msg_cnt_q == MC_W'(K_MAX - 1)));
  assign emit_par = en && (state_q == ST_DRAIN) && !s1_valid;
  assign par_last = emit_par && (par_cnt_q == PC_W'(N_PAR - 1));

  always_comb begin
    state_d   = state_q;
    msg_cnt_d = msg_cnt_q;
    par_cnt_d = par_cnt_q;
    case (state_q)
      ST_DATA: begin
        if (last_sym) begin
          state_d   = ST_DRAIN;
          msg_cnt_d = '0;
        end else if (accept) begin
          msg_cnt_d = msg_cnt_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        if (par_last) begin
          state_d   = ST_DATA;
          par_cnt_d = '0;
        end else if (emit_par) begin
          par_cnt_d = par_cnt_q + 1'b1;
        end
      end
      default: state_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_DATA;
      msg_cnt_q <= '0;
      par_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      msg_cnt_q <= msg_cnt_d;
      par_cnt_q <= par_cnt_d;
    end
  end

  // R5: no input is taken while check symbols are pending
  a_r5_drain_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> !in_ready);
  // R8: the message counter never passes the length limit
  a_r8_msg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    msg_cnt_q < MC_W'(K_MAX));
  // R3: parity counter idles at zero outside the drain phase
  a_r3_par_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (par_cnt_q == '0));
endmodule

// File: rtl/rs_stream_encoder.sv
module rs_stream_encoder
  import rs_enc_pkg::*;
#(
  parameter int K_MAX = 239,
  parameter int N_PAR = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [SYM_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sop,
  output logic             out_eop,
  output logic [SYM_W-1:0] out_data
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic en, accept, emit_par, par_last, par_empty;
  sym_t par_top;

  logic s1_valid_q, s1_valid_d, s1_sop_q, s1_sop_d;
  sym_t s1_data_q, s1_data_d;
  logic o_valid_q, o_valid_d, o_sop_q, o_sop_d, o_eop_q, o_eop_d;
  sym_t o_data_q, o_data_d;

  assign en = out_ready;

  rs_enc_ctrl #(.K_MAX(K_MAX), .N_PAR(N_PAR)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sn),
    .en       (en),
    .in_valid (in_valid),
    .in_eop   (in_eop),
    .s1_valid (s1_valid_q),
    .in_ready (in_ready),
    .accept   (accept),
    .emit_par (emit_par),
    .par_last (par_last)
  );

  rs_parity_lfsr #(.N_PAR(N_PAR)) u_lfsr (
    .clk       (clk),
    .rst_n     (rst_sn),
    .absorb    (en && s1_valid_q),
    .emit      (emit_par),
    .din       (s1_data_q),
    .par_top   (par_top),
    .par_empty (par_empty)
  );

  always_comb begin
    s1_valid_d = s1_valid_q;
    s1_data_d  = s1_data_q;
    s1_sop_d   = s1_sop_q;
    o_valid_d  = o_valid_q;
    o_data_d   = o_data_q;
    o_sop_d    = o_sop_q;
    o_eop_d    = o_eop_q;
    if (en) begin
      s1_valid_d = accept;
      if (accept) begin
        s1_data_d = in_data;
        s1_sop_d  = in_sop;
      end
      o_valid_d = s1_valid_q || emit_par;
      if (s1_valid_q) begin
        o_data_d = s1_data_q;
        o_sop_d  = s1_sop_q;
        o_eop_d  = 1'b0;
      end else if (emit_par) begin
        o_data_d = par_top;
        o_sop_d  = 1'b0;
        o_eop_d  = par_last;
      end else begin
        o_sop_d  = 1'b0;
        o_eop_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s1_valid_q <= 1'b0;
      s1_data_q  <= '0;
      s1_sop_q   <= 1'b0;
      o_valid_q  <= 1'b0;
      o_data_q   <= '0;
      o_sop_q    <= 1'b0;
      o_eop_q    <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_data_q  <= s1_data_d;
      s1_sop_q   <= s1_sop_d;
      o_valid_q  <= o_valid_d;
      o_data_q   <= o_data_d;
      o_sop_q    <= o_sop_d;
      o_eop_q    <= o_eop_d;
    end
  end

  assign out_valid = o_valid_q;
  assign out_data  = o_data_q;
  assign out_sop   = o_sop_q;
  assign out_eop   = o_eop_q;

  // R2: an accepted symbol is staged on the next cycle
  a_r2_stage_fill: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && in_ready) |=> s1_valid_q);
  // R2: a staged symbol reaches the output unchanged
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_sn)
    (s1_valid_q && out_ready) |=> (out_valid && out_data == $past(s1_data_q) && !out_eop));
  // R6: stalled output holds
  a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));
  // R6: no input while the output is stalled
  a_r6_no_input_when_stalled: assert property (@(posedge clk) disable iff (!rst_sn)
    !out_ready |-> !in_ready);
  // R10: parity bank is clean after the final check symbol
  a_r10_bank_cleared: assert property (@(posedge clk) disable iff (!rst_sn)
    par_last |=> par_empty);
  // R3: end flag only on a presented symbol
  a_r3_eop_with_valid: assert property (@(posedge clk) disable iff (!rst_sn)
    out_eop |-> (out_valid && !out_sop));
endmodule

// File: tb/tb_rs_stream_encoder.sv
`timescale 1ns/1ps
module tb_rs_stream_encoder;
  localparam int K_MAX = 239;
  localparam int N_PAR = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_sop, in_eop;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_sop, out_eop;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  rs_stream_encoder #(.K_MAX(K_MAX), .N_PAR(N_PAR)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  int errors = 0;
  int checks = 0;

  function automatic logic [7:0] tgf_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] x = a;
    logic [7:0] y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) acc = acc ^ x;
      y = y >> 1;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return acc;
  endfunction

  task automatic check(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic [7:0] msg_buf [K_MAX];
  int         cur_len, cur_idx;
  bit         cur_active, cur_noeop;
  int         plen_q[$];
  bit         pnoeop_q[$];
  logic [7:0] exp_syms[$];
  int         exp_len[$];
  logic [7:0] got[$];
  int         pv, pr, cyc;
  int         t_first_acc, t_sop_out, t_eop_acc, t_ready_back, t_eop_out;
  bit         wait_ready;
  bit         prev_stall;
  logic [7:0] prev_data;
  logic       prev_sop, prev_eop;

  task automatic finish_pkt();
    int L;
    int mism;
    int bad;
    logic [7:0] root;
    logic [7:0] s;
    L = (exp_len.size() > 0) ? exp_len.pop_front() : -1;
    check(got.size() == L + N_PAR, "R3,R7", "codeword length", got.size(), L + N_PAR);
    mism = 0;
    for (int i = 0; i < L; i++) begin
      logic [7:0] e;
      e = (exp_syms.size() > 0) ? exp_syms.pop_front() : 8'h00;
      if (i >= got.size() || got[i] != e) mism++;
    end
    check(mism == 0, "R1,R2,R11", "message symbol mismatches", mism, 0);
    bad = 0;
    root = 8'h01;
    for (int r = 0; r < N_PAR; r++) begin
      s = 8'h00;
      foreach (got[k]) s = tgf_mul(s, root) ^ got[k];
      if (s != 8'h00) bad++;
      root = tgf_mul(root, 8'h02);
    end
    check(bad == 0, "R4,R10", "nonzero syndromes", bad, 0);
    got.delete();
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (!cur_active && plen_q.size() > 0) begin
      cur_len    = plen_q.pop_front();
      cur_noeop  = pnoeop_q.pop_front();
      cur_idx    = 0;
      cur_active = 1'b1;
      for (int i = 0; i < cur_len; i++) msg_buf[i] = 8'($urandom);
      exp_len.push_back(cur_len);
    end
    out_ready = ($urandom_range(99) < pr);
    if (cur_active && ($urandom_range(99) < pv)) begin
      in_valid = 1'b1;
      in_data  = msg_buf[cur_idx];
      in_sop   = (cur_idx == 0);
      in_eop   = (cur_idx == cur_len - 1) && !cur_noeop;
    end else begin
      in_valid = 1'b0;
      in_data  = 8'($urandom);
      in_sop   = 1'($urandom);
      in_eop   = 1'($urandom);
    end
    #1;
    if (prev_stall)
      check(out_valid && out_data == prev_data && out_sop == prev_sop && out_eop == prev_eop,
            "R6", "output held under stall", out_data, prev_data);
    if (!out_ready) check(!in_ready, "R6", "in_ready while output stalled", in_ready, 0);
    if (wait_ready && in_ready) begin
      t_ready_back = cyc;
      wait_ready   = 1'b0;
    end
    if (in_valid && in_ready) begin
      exp_syms.push_back(in_data);
      if (cur_idx == 0) t_first_acc = cyc;
      cur_idx++;
      if (cur_idx == cur_len) begin
        cur_active = 1'b0;
        t_eop_acc  = cyc;
        wait_ready = 1'b1;
      end
    end
    if (out_valid && out_ready) begin
      if (got.size() == 0) t_sop_out = cyc;
      check(out_sop == (got.size() == 0), "R2", "out_sop placement", out_sop, int'(got.size() == 0));
      got.push_back(out_data);
      if (out_eop) begin
        t_eop_out = cyc;
        finish_pkt();
      end else if (got.size() > K_MAX + N_PAR) begin
        check(0, "R3", "codeword without end flag", got.size(), K_MAX + N_PAR);
        got.delete();
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    prev_sop   = out_sop;
    prev_eop   = out_eop;
  endtask

  task automatic run_until_idle();
    while (plen_q.size() > 0 || cur_active || exp_len.size() > 0) step();
    repeat (3) step();
  endtask

  task automatic add_pkt(int len, bit noeop);
    plen_q.push_back(len);
    pnoeop_q.push_back(noeop);
  endtask

  initial begin
    #(5ns * 190000);
    check(0, "R1", "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_sop     = 1'b0;
    in_eop     = 1'b0;
    in_data    = 8'h00;
    out_ready  = 1'b1;
    cur_active = 1'b0;
    wait_ready = 1'b0;
    prev_stall = 1'b0;
    cyc        = 0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R9", "out_valid during reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R9", "out_valid after reset", out_valid, 0);
    check(in_ready, "R9", "in_ready after reset", in_ready, 1);

    // Full-rate short message: latency, drain length, end position
    pv = 100; pr = 100;
    add_pkt(5, 1'b0);
    run_until_idle();
    check(t_sop_out - t_first_acc == 2, "R2", "pass-through latency", t_sop_out - t_first_acc, 2);
    check(t_ready_back - t_eop_acc == 18, "R1,R5", "input stall length plus one", t_ready_back - t_eop_acc, 18);
    check(t_eop_out - t_eop_acc == 18, "R3", "final check symbol position", t_eop_out - t_eop_acc, 18);

    // Full length closed by the counter, no end flag
    add_pkt(K_MAX, 1'b1);
    run_until_idle();
    check(t_eop_out - t_eop_acc == 18, "R8", "drain after 239th symbol", t_eop_out - t_eop_acc, 18);

    // Directed corners back to back
    add_pkt(1, 1'b0);
    add_pkt(2, 1'b0);
    add_pkt(K_MAX, 1'b0);
    add_pkt(1, 1'b0);
    run_until_idle();

    // Random lengths at full rate
    for (int i = 0; i < 10; i++) add_pkt($urandom_range(K_MAX, 1), 1'b0);
    run_until_idle();

    // Random lengths with gaps on both sides
    pv = 70; pr = 65;
    for (int i = 0; i < 25; i++) add_pkt($urandom_range(K_MAX, 1), 1'b0);
    add_pkt(K_MAX, 1'b1);
    add_pkt(3, 1'b0);
    run_until_idle();

    check(exp_syms.size() == 0, "R2", "leftover message symbols", exp_syms.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule